// File: doc/BRIEF.md
# Mixed-Width Dual-Port Memory

This block is an 18,432-bit synchronous memory with two ports, A and B, that work at the same time. A parameter sets each port to one of six shapes: 16384x1, 8192x2, 4096x4, 2048x9, 1024x18 or 512x36. The two ports can have different shapes. Both ports reach the same storage, so a word written through one port can be read back through the other in that port's own width. This lets the memory act as a width converter with no extra logic.

The storage has 16,384 data bits and 2,048 extra bits. The extra bits can only be reached in the 9-, 18- and 36-bit shapes, where they sit above the data bits of the port word. Each port has its own enable, write enable, output reset, address, write data and read data. Both ports are registered on one shared clock edge, so the array has a single writer process. Two writes to the same bit in the same cycle leave that bit undefined, and callers must avoid them.

If the top address bit of port A is held low and the top address bit of port B is held high, the memory behaves as two separate half-size memories.

Top module: `tdp_mix_ram`

## Requirements
- R1: Port address width is 9 + 5 - log2(D), where D is the data-bit count of the port (1, 2, 4, 8, 16 or 32 for widths 1, 2, 4, 9, 18, 36). Every address from 0 to the top one is usable, and the top address of every port ends at the last data bit of the array.
- R2: Port word at address `a` holds array data bits a*D to a*D+D-1 in ascending order. A narrower port's lowest address inside a wider word therefore maps to that word's lowest data bits.
- R3: In the 9-, 18- and 36-bit shapes the port word is {extra bits, data bits}: the P = W/9 extra bits occupy port bits [W-1:D]. At address `a` they are array extra bits a*P to a*P+P-1, so extra bit k goes with data byte k.
- R4: A port writes its word at the clock edge where its enable and write enable are both high.
- R5: A read with enable high and write enable low shows the stored word on that port's read data after that edge.
- R6: On a write, the port's read data takes the written word at the same edge.
- R7: With enable low, a port neither writes nor changes its read data, whatever its write enable, address and data are.
- R8: Output reset high clears the port's read data to zero at the edge, whether or not the port is enabled, and leaves the stored contents as they were.
- R9: Both ports can read and write in the same cycle. This includes writes to different bits of the same array row, and both writes land.
- R10: With A's top address bit at 0 and B's at 1, the two ports use disjoint halves of the array and do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| rst_a | input | 1 | Port A synchronous read-data clear |
| addr_a | input | 9 to 14, from WIDTH_A | Port A word address |
| din_a | input | WIDTH_A | Port A write word |
| dout_a | output | WIDTH_A | Port A registered read word |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| rst_b | input | 1 | Port B synchronous read-data clear |
| addr_b | input | 9 to 14, from WIDTH_B | Port B word address |
| din_b | input | WIDTH_B | Port B write word |
| dout_b | output | WIDTH_B | Port B registered read word |

## Verification
The bench builds the block with port A at 18 bits and port B at 9 bits. With these widths each 36-bit row is split into two A slots and four B slots, and both shapes carry extra bits. This covers cross-width readback of data and extra bits, a same-row write from both ports to disjoint bits (the merge path), and the top address of each port. The 1-, 2-, 4- and 36-bit shapes are not built by this bench, so the zero-slot-bit variant of the address split stays outside it.

// File: rtl/tdp_mix_pkg.sv
package tdp_mix_pkg;
  localparam int ROWS      = 512;
  localparam int ROW_IDX_W = $clog2(ROWS);
  localparam int ROW_DATA  = 32;
  localparam int ROW_PAR   = 4;
  localparam int ROW_W     = ROW_DATA + ROW_PAR;

  typedef logic [ROW_W-1:0]     row_t;
  typedef logic [ROW_IDX_W-1:0] row_idx_t;

  function automatic bit width_ok(int w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 9) || (w == 18) || (w == 36);
  endfunction

  function automatic int data_w(int w);
    return (w >= 9) ? (w / 9) * 8 : w;
  endfunction

  function automatic int par_w(int w);
    return (w >= 9) ? w / 9 : 0;
  endfunction

  function automatic int addr_w(int w);
    return ROW_IDX_W + $clog2(ROW_DATA) - $clog2(data_w(w));
  endfunction

  function automatic int slot_w(int w);
    return addr_w(w) - ROW_IDX_W;
  endfunction

  function automatic logic [ROW_DATA-1:0] dlow(int dw);
    return ROW_DATA'((33'(1) << dw) - 33'(1));
  endfunction

  function automatic logic [ROW_PAR-1:0] plow(int pw);
    return ROW_PAR'((5'(1) << pw) - 5'(1));
  endfunction

  // row bits covered by one port slot
  function automatic row_t lane_mask(int dw, int pw, logic [5:0] slot);
    logic [ROW_DATA-1:0] d;
    logic [ROW_PAR-1:0]  p;
    d = dlow(dw) << (slot * dw);
    p = plow(pw) << (slot * pw);
    return {p, d};
  endfunction

  // port word -> row positions
  function automatic row_t lane_spread(row_t pword, int dw, int pw, logic [5:0] slot);
    logic [ROW_DATA-1:0] d;
    logic [ROW_PAR-1:0]  p;
    d = pword[ROW_DATA-1:0] & dlow(dw);
    p = ROW_PAR'(pword >> dw) & plow(pw);
    return {p << (slot * pw), d << (slot * dw)};
  endfunction

  // row -> port word {extra, data}
  function automatic row_t lane_gather(row_t row, int dw, int pw, logic [5:0] slot);
    logic [ROW_DATA-1:0] d;
    logic [ROW_PAR-1:0]  p;
    d = (row[ROW_DATA-1:0] >> (slot * dw)) & dlow(dw);
    p = (row[ROW_W-1:ROW_DATA] >> (slot * pw)) & plow(pw);
    return row_t'(d) | (row_t'(p) << dw);
  endfunction
endpackage

// File: rtl/tdp_mix_lane.sv
module tdp_mix_lane
  import tdp_mix_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic                       clk,
  input  logic                       en,
  input  logic                       we,
  input  logic                       rst,
  input  logic [addr_w(WIDTH)-1:0]   addr,
  input  logic [WIDTH-1:0]           din,
  output logic [WIDTH-1:0]           dout,
  input  row_t                       row_word,
  output row_idx_t                   row,
  output logic                       wr_en,
  output row_t                       wr_mask,
  output row_t                       wr_bits
);
  localparam int DW = data_w(WIDTH);
  localparam int PW = par_w(WIDTH);
  localparam int AW = addr_w(WIDTH);
  localparam int SW = slot_w(WIDTH);

  logic [5:0] slot;

  generate
    if (SW > 0) begin : g_slot
      assign slot = 6'(addr[SW-1:0]);
    end else begin : g_noslot
      assign slot = '0;
    end
  endgenerate

  assign row     = addr[AW-1 -: ROW_IDX_W];
  assign wr_en   = en & we;
  assign wr_mask = lane_mask(DW, PW, slot);
  assign wr_bits = lane_spread(row_t'(din), DW, PW, slot);

  always_ff @(posedge clk) begin
    if (rst)     dout <= '0;
    else if (en) dout <= we ? din : WIDTH'(lane_gather(row_word, DW, PW, slot));
  end

  // R2
  mask_width_chk: assert property (@(posedge clk) wr_en |-> $countones(wr_mask) == WIDTH);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(dout));
  // R6
  write_first_chk: assert property (@(posedge clk) (en && we && !rst) |=> dout == $past(din));
  // R8
  out_clear_chk: assert property (@(posedge clk) rst |=> dout == '0);
endmodule

// File: rtl/tdp_mix_array.sv
module tdp_mix_array
  import tdp_mix_pkg::*;
(
  input  logic     clk,
  input  logic     wr_a,
  input  row_idx_t row_a,
  input  row_t     mask_a,
  input  row_t     bits_a,
  input  logic     wr_b,
  input  row_idx_t row_b,
  input  row_t     mask_b,
  input  row_t     bits_b,
  output row_t     word_a,
  output row_t     word_b
);
  row_t mem [ROWS];
  logic same_row;

  assign same_row = wr_a && wr_b && (row_a == row_b);

  always_ff @(posedge clk) begin
    if (same_row) begin
      mem[row_a] <= (mem[row_a] & ~(mask_a | mask_b)) | (bits_a & mask_a) | (bits_b & mask_b & ~mask_a);
    end else begin
      if (wr_a) mem[row_a] <= (mem[row_a] & ~mask_a) | (bits_a & mask_a);
      if (wr_b) mem[row_b] <= (mem[row_b] & ~mask_b) | (bits_b & mask_b);
    end
  end

  assign word_a = mem[row_a];
  assign word_b = mem[row_b];

  // R4
  a_lands_chk: assert property (@(posedge clk) (wr_a && !same_row) |=>
    ((mem[$past(row_a)] & $past(mask_a)) == ($past(bits_a) & $past(mask_a))));
  // R4
  b_lands_chk: assert property (@(posedge clk) (wr_b && !same_row && !(wr_a && row_a == row_b)) |=>
    ((mem[$past(row_b)] & $past(mask_b)) == ($past(bits_b) & $past(mask_b))));
  // R9
  shared_row_chk: assert property (@(posedge clk) (same_row && ((mask_a & mask_b) == '0)) |=>
    ((mem[$past(row_a)] & $past(mask_a | mask_b)) ==
     (($past(bits_a) & $past(mask_a)) | ($past(bits_b) & $past(mask_b)))));
endmodule

// File: rtl/tdp_mix_ram.sv
module tdp_mix_ram
  import tdp_mix_pkg::*;
#(
  parameter int WIDTH_A = 18,
  parameter int WIDTH_B = 9
) (
  input  logic                        clk,
  input  logic                        en_a,
  input  logic                        we_a,
  input  logic                        rst_a,
  input  logic [addr_w(WIDTH_A)-1:0]  addr_a,
  input  logic [WIDTH_A-1:0]          din_a,
  output logic [WIDTH_A-1:0]          dout_a,
  input  logic                        en_b,
  input  logic                        we_b,
  input  logic                        rst_b,
  input  logic [addr_w(WIDTH_B)-1:0]  addr_b,
  input  logic [WIDTH_B-1:0]          din_b,
  output logic [WIDTH_B-1:0]          dout_b
);
  generate
    if (!width_ok(WIDTH_A) || !width_ok(WIDTH_B)) begin : g_bad_width
      $error("tdp_mix_ram: port width must be 1, 2, 4, 9, 18 or 36");
    end
  endgenerate

  row_idx_t row_a, row_b;
  logic     wr_a, wr_b;
  row_t     mask_a, mask_b, bits_a, bits_b, word_a, word_b;

  tdp_mix_lane #(.WIDTH(WIDTH_A)) lane_a_i (
    .clk(clk), .en(en_a), .we(we_a), .rst(rst_a), .addr(addr_a), .din(din_a), .dout(dout_a),
    .row_word(word_a), .row(row_a), .wr_en(wr_a), .wr_mask(mask_a), .wr_bits(bits_a)
  );

  tdp_mix_lane #(.WIDTH(WIDTH_B)) lane_b_i (
    .clk(clk), .en(en_b), .we(we_b), .rst(rst_b), .addr(addr_b), .din(din_b), .dout(dout_b),
    .row_word(word_b), .row(row_b), .wr_en(wr_b), .wr_mask(mask_b), .wr_bits(bits_b)
  );

  tdp_mix_array array_i (
    .clk(clk),
    .wr_a(wr_a), .row_a(row_a), .mask_a(mask_a), .bits_a(bits_a),
    .wr_b(wr_b), .row_b(row_b), .mask_b(mask_b), .bits_b(bits_b),
    .word_a(word_a), .word_b(word_b)
  );
endmodule

// File: tb/tdp_mix_ram_tb.sv
`timescale 1ns/1ps
module tdp_mix_ram_tb_top;
  localparam int WA  = 18;
  localparam int WB  = 9;
  localparam int AWA = 10;
  localparam int AWB = 11;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           en_a = 0, we_a = 0, rst_a = 0, en_b = 0, we_b = 0, rst_b = 0;
  logic [AWA-1:0] addr_a = '0;
  logic [AWB-1:0] addr_b = '0;
  logic [WA-1:0]  din_a = '0;
  logic [WB-1:0]  din_b = '0;
  logic [WA-1:0]  dout_a;
  logic [WB-1:0]  dout_b;

  tdp_mix_ram #(.WIDTH_A(WA), .WIDTH_B(WB)) dut_i (
    .clk(clk), .en_a(en_a), .we_a(we_a), .rst_a(rst_a), .addr_a(addr_a), .din_a(din_a), .dout_a(dout_a),
    .en_b(en_b), .we_b(we_b), .rst_b(rst_b), .addr_b(addr_b), .din_b(din_b), .dout_b(dout_b)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  logic [35:0] model [512];
  logic [35:0] cur_a = '0, cur_b = '0;
  logic [35:0] qa_val [$];
  logic [35:0] qb_val [$];
  string       qa_tag [$];
  string       qb_tag [$];

  function automatic int dbits(int w);
    case (w)
      9: return 8;
      18: return 16;
      36: return 32;
      default: return w;
    endcase
  endfunction

  function automatic logic [35:0] mread(int w, int a);
    logic [35:0] r = '0;
    int dw = dbits(w);
    int pw = w - dw;
    for (int i = 0; i < dw; i++) begin int d; d = a * dw + i; r[i] = model[d / 32][d % 32]; end
    for (int j = 0; j < pw; j++) begin int p; p = a * pw + j; r[dw + j] = model[p / 4][32 + p % 4]; end
    return r;
  endfunction

  task automatic mwrite(int w, int a, logic [35:0] v);
    int dw = dbits(w);
    int pw = w - dw;
    for (int i = 0; i < dw; i++) begin int d; d = a * dw + i; model[d / 32][d % 32] = v[i]; end
    for (int j = 0; j < pw; j++) begin int p; p = a * pw + j; model[p / 4][32 + p % 4] = v[dw + j]; end
  endtask

  // driver: one cycle on both ports, expected words pushed to the scoreboard
  task automatic step(bit ea, bit wa, bit ra, int aa, logic [35:0] da,
                      bit eb, bit wb, bit rb, int ab, logic [35:0] db, string tag);
    logic [35:0] xa, xb, ma, mb;
    @(negedge clk); #1;
    ma = 36'(da[WA-1:0]);
    mb = 36'(db[WB-1:0]);
    en_a = ea; we_a = wa; rst_a = ra; addr_a = AWA'(aa); din_a = ma[WA-1:0];
    en_b = eb; we_b = wb; rst_b = rb; addr_b = AWB'(ab); din_b = mb[WB-1:0];
    xa = ra ? 36'd0 : (ea ? (wa ? ma : mread(WA, aa)) : cur_a);
    xb = rb ? 36'd0 : (eb ? (wb ? mb : mread(WB, ab)) : cur_b);
    if (ea && wa) mwrite(WA, aa, ma);
    if (eb && wb) mwrite(WB, ab, mb);
    cur_a = xa; cur_b = xb;
    qa_val.push_back(xa); qa_tag.push_back(tag);
    qb_val.push_back(xb); qb_tag.push_back(tag);
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // monitor
  always @(negedge clk) begin : mon
    logic [35:0] e;
    string t;
    if (qa_val.size() > 0) begin
      e = qa_val.pop_front(); t = qa_tag.pop_front(); total++;
      if (36'(dout_a) !== e) begin bad++; $display("FAIL %s port A: actual %h expected %h", t, dout_a, e); end
    end
    if (qb_val.size() > 0) begin
      e = qb_val.pop_front(); t = qb_tag.pop_front(); total++;
      if (36'(dout_b) !== e) begin bad++; $display("FAIL %s port B: actual %h expected %h", t, dout_b, e); end
    end
  end

  initial begin
    #(5.0 * 50000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 512; r++) model[r] = '0;
    // R8 reset state of both outputs
    step(0, 0, 1, 0, 0, 0, 0, 1, 0, 0, "R8 reset state");
    // fill the array through A (R4, R6), B idle holds (R7)
    for (int a = 0; a < 1024; a++)
      step(1, 1, 0, a, 36'((a * 18'h1F3) ^ 18'h2A5A5), 0, 0, 0, 0, 0, "R4 R6 R7 fill");
    // R5 A read back; R2 R3 B cross-width read of every address
    for (int i = 0; i < 2048; i++)
      step(1, 0, 0, (i * 5) % 1024, 0, 1, 0, 0, i, 0, "R2 R3 R5 cross read");
    // R2 R3 B writes four bytes with extra bits, A reads the two words
    for (int k = 0; k < 4; k++)
      step(0, 0, 0, 0, 0, 1, 1, 0, 40 + k, 36'(9'h100 | (k * 9'h45)), "R2 R3 narrow write");
    step(1, 0, 0, 20, 0, 0, 0, 0, 0, 0, "R2 R3 wide read low");
    step(1, 0, 0, 21, 0, 0, 0, 0, 0, 0, "R2 R3 wide read high");
    // R9 both ports write disjoint bits of row 15 in one cycle
    step(1, 1, 0, 30, 36'h3_C3A5, 1, 1, 0, 62, 36'h1_7E, "R9 shared row write");
    step(1, 0, 0, 30, 0, 1, 0, 0, 62, 0, "R9 shared row read");
    step(1, 0, 0, 31, 0, 1, 0, 0, 60, 0, "R9 shared row others");
    // R7 enable low with write enable high: no write, output holds
    step(0, 1, 0, 30, 36'h3_FFFF, 0, 1, 0, 62, 36'h1FF, "R7 disabled write");
    step(1, 0, 0, 30, 0, 1, 0, 0, 62, 0, "R7 contents unchanged");
    // R8 clear while enabled, contents intact; also clear while disabled
    step(1, 0, 1, 30, 0, 0, 0, 1, 0, 0, "R8 clear");
    step(1, 0, 0, 30, 0, 1, 0, 0, 61, 0, "R8 contents kept");
    step(1, 1, 1, 31, 36'h0_1234, 0, 0, 0, 0, 0, "R8 clear during write");
    step(1, 0, 0, 31, 0, 0, 0, 0, 0, 0, "R8 write under clear lands");
    // R1 top and bottom addresses of both ports
    step(1, 1, 0, 1023, 36'h2_9B17, 1, 1, 0, 0, 36'h0_C4, "R1 extreme write");
    step(1, 0, 0, 0, 0, 1, 0, 0, 2047, 0, "R1 extreme read");
    step(1, 0, 0, 1023, 0, 1, 0, 0, 2046, 0, "R1 top word");
    // R10 split halves: A below, B above, mixed reads and writes
    for (int i = 0; i < 64; i++) begin
      int aa, ab;
      aa = ((i >> 1) * 7) % 512;
      ab = 1024 + ((i >> 1) * 13) % 1024;
      step(1, !i[0], 0, aa, 36'(i * 18'h0AB1), 1, !i[0], 0, ab, 36'(i * 9'h05D), "R10 split halves");
    end
    for (int i = 0; i < 32; i++)
      step(1, 0, 0, (i * 7) % 512, 0, 1, 0, 0, 1024 + (i * 13) % 1024, 0, "R10 split readback");
    idle("drain");
    idle("drain");
    @(negedge clk); @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule